// File: doc/BRIEF.md
# Dual Look-Up Table Slice with Memory and Shift Modes

This block models a logic slice built from two 16-bit storage arrays, each addressed by four select bits. The same array serves as the truth table of a 4-input combinational function, as a 16-word by 1-bit memory with a clocked write, or as a 16-stage serial shift register with a selectable tap. The two arrays can also be paired. Pairing gives a 16-word by 2-bit memory, a 32-word by 1-bit memory, or a 16-word by 1-bit memory with one read/write port and one separate read-only port.

A configuration port writes whole truth tables and the mode register. In operation, the select bits read the arrays without a clock. The shared write enable gates every clocked write and shift. A third output carries the result of the paired modes.

Top module: `lut_slice`

## Requirements
- R1: After reset the mode register holds 0 (function mode), both tables hold all zeros, and outA, outB and outWide are 0.
- R2: On a rising edge with cfgLoad high, cfgTarget 0 loads table A with cfgData, target 1 loads table B, target 2 loads the mode register from cfgData[2:0], and target 3 changes nothing. A table being loaded takes cfgData even when a write or shift to it happens in the same cycle.
- R3: In mode 0 (function), outA is table A bit addrA and outB is table B bit addrB. Both outputs follow the address without a clock. wrEn, wrData and shiftIn leave both tables unchanged.
- R4: In mode 1 (two 16x1 memories), a rising edge with wrEn high writes wrData[0] into table A at addrA and wrData[1] into table B at addrB. Reads are the same as in mode 0.
- R5: In mode 2 (16x2 memory), a write stores wrData[0] into table A and wrData[1] into table B, both at addrA. outA and outB both read at addrA.
- R6: In mode 3 (32x1 memory), a write stores wrData[0] at addrA into table B when addrHi is 1 and into table A when addrHi is 0. The other table is left unchanged. outWide reads the table that addrHi selects, at addrA.
- R7: In mode 4 (dual-port), a write stores wrData[0] at addrA into both tables. outA reads table A at addrA. outB and outWide read table B at addrB.
- R8: In mode 5 (shift), a rising edge with wrEn high moves each table one place toward bit 15 and enters shiftIn[0] into bit 0 of table A and shiftIn[1] into bit 0 of table B. outA taps table A at addrA and outB taps table B at addrB. With wrEn low the tables hold.
- R9: Mode values 6 and 7 behave exactly as mode 0.
- R10: outWide equals outA in every mode other than 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | Configuration load strobe |
| cfgTarget | input | 2 | Load target: 0 table A, 1 table B, 2 mode, 3 none |
| cfgData | input | 16 | Truth-table contents, or mode in bits 2:0 |
| addrA | input | 4 | Select / address for table A and the write port |
| addrB | input | 4 | Select / address for table B and the read-only port |
| addrHi | input | 1 | Fifth address bit in 32x1 mode |
| wrEn | input | 1 | Write / shift enable |
| wrData | input | 2 | Write data, bit 0 for table A, bit 1 for table B |
| shiftIn | input | 2 | Serial inputs, bit 0 for table A, bit 1 for table B |
| outA | output | 1 | Read of table A |
| outB | output | 1 | Read of table B |
| outWide | output | 1 | Paired-mode output |

## Verification
All reads are combinational, so a wrong stored bit shows up at outA or outB as soon as that address is selected, within the same cycle. The bench can therefore find a corrupted table by sweeping all sixteen addresses in function mode after each scenario. A write steered to the wrong table or the wrong address, a shift in the wrong direction, or a write that leaks into function mode all leave at least one bit that differs from the bench model. A wrong mode decode changes which table or address drives outB or outWide one cycle after the mode load.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;
  localparam int LUT_IN   = 4;
  localparam int LUT_BITS = 1 << LUT_IN;
  localparam int MODE_W   = 3;
  localparam int N_TAB    = 2;

  localparam logic [MODE_W-1:0] MODE_FUNC  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_RAM1  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_RAM2W = 3'd2;
  localparam logic [MODE_W-1:0] MODE_RAM32 = 3'd3;
  localparam logic [MODE_W-1:0] MODE_DUAL  = 3'd4;
  localparam logic [MODE_W-1:0] MODE_SHIFT = 3'd5;

  localparam logic [1:0] TGT_TAB_A = 2'd0;
  localparam logic [1:0] TGT_TAB_B = 2'd1;
  localparam logic [1:0] TGT_MODE  = 2'd2;

  typedef struct packed {
    logic [N_TAB-1:0]             load;
    logic [N_TAB-1:0]             write;
    logic [N_TAB-1:0]             shift;
    logic [N_TAB-1:0]             wrBit;
    logic [N_TAB-1:0]             shIn;
    logic [N_TAB-1:0][LUT_IN-1:0] wrAddr;
    logic [N_TAB-1:0][LUT_IN-1:0] rdAddr;
    logic                         wideUseB;
  } sliceStrobe_t;
endpackage

// File: rtl/lut_cell.sv
module lut_cell
  import lut_slice_pkg::*;
#(
  parameter int IN_W = LUT_IN
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  load,
  input  logic [(1<<IN_W)-1:0]  loadData,
  input  logic                  write,
  input  logic [IN_W-1:0]       wrAddr,
  input  logic                  wrBit,
  input  logic                  shift,
  input  logic                  shIn,
  input  logic [IN_W-1:0]       rdAddr,
  output logic                  rdOut
);
  localparam int DEPTH = 1 << IN_W;

  logic [DEPTH-1:0] mem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mem <= '0;
    end else if (load) begin
      mem <= loadData;
    end else if (write) begin
      mem[wrAddr] <= wrBit;
    end else if (shift) begin
      mem <= {mem[DEPTH-2:0], shIn};
    end
  end

  assign rdOut = mem[rdAddr];

  // R2: a load replaces the whole table
  a_r2_load_whole: assert property (@(posedge clk) disable iff (!rstN)
    load |=> mem == $past(loadData));

  // R4: a write lands at its address
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (write && !load) |=> mem[$past(wrAddr)] == $past(wrBit));

  // R4: a write touches at most one bit
  a_r4_write_one_bit: assert property (@(posedge clk) disable iff (!rstN)
    (write && !load) |=> $countones(mem ^ $past(mem)) <= 1);

  // R8: a shift moves toward the top bit
  a_r8_shift_order: assert property (@(posedge clk) disable iff (!rstN)
    (shift && !load) |=> mem == {$past(mem[DEPTH-2:0]), $past(shIn)});

  // R3: with no strobe the table holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !write && !shift) |=> $stable(mem));

  // R8: write and shift never coincide
  a_r8_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(write && shift));
endmodule

// File: rtl/slice_ctrl.sv
module slice_ctrl
  import lut_slice_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgLoad,
  input  logic [1:0]         cfgTarget,
  input  logic [MODE_W-1:0]  cfgModeBits,
  input  logic [LUT_IN-1:0]  addrA,
  input  logic [LUT_IN-1:0]  addrB,
  input  logic               addrHi,
  input  logic               wrEn,
  input  logic [N_TAB-1:0]   wrData,
  input  logic [N_TAB-1:0]   shiftIn,
  output sliceStrobe_t       strb,
  output logic [MODE_W-1:0]  modeCur
);
  logic modeWr;
  assign modeWr = cfgLoad && (cfgTarget == TGT_MODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       modeCur <= MODE_FUNC;
    else if (modeWr) modeCur <= cfgModeBits;
  end

  always_comb begin
    strb          = '0;
    strb.load[0]  = cfgLoad && (cfgTarget == TGT_TAB_A);
    strb.load[1]  = cfgLoad && (cfgTarget == TGT_TAB_B);
    strb.wrAddr[0] = addrA;
    strb.wrAddr[1] = addrB;
    strb.rdAddr[0] = addrA;
    strb.rdAddr[1] = addrB;
    strb.wrBit    = wrData;
    strb.shIn     = shiftIn;
    case (modeCur)
      MODE_RAM1: begin
        strb.write = {N_TAB{wrEn}};
      end
      MODE_RAM2W: begin
        strb.write     = {N_TAB{wrEn}};
        strb.wrAddr[1] = addrA;
        strb.rdAddr[1] = addrA;
      end
      MODE_RAM32: begin
        strb.write     = {wrEn & addrHi, wrEn & ~addrHi};
        strb.wrAddr[1] = addrA;
        strb.rdAddr[1] = addrA;
        strb.wrBit     = {N_TAB{wrData[0]}};
        strb.wideUseB  = addrHi;
      end
      MODE_DUAL: begin
        strb.write     = {N_TAB{wrEn}};
        strb.wrAddr[1] = addrA;
        strb.wrBit     = {N_TAB{wrData[0]}};
        strb.wideUseB  = 1'b1;
      end
      MODE_SHIFT: begin
        strb.shift = {N_TAB{wrEn}};
      end
      default: ;
    endcase
  end

  // R3 R9: function mode and unused codes never alter tables
  a_r3_func_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (modeCur == MODE_FUNC || modeCur > MODE_SHIFT) |-> (strb.write == '0 && strb.shift == '0));

  // R6: the deep memory writes one table at a time
  a_r6_one_table: assert property (@(posedge clk) disable iff (!rstN)
    (modeCur == MODE_RAM32) |-> $countones(strb.write) <= 1);

  // R2: the mode register follows a mode load
  a_r2_mode_load: assert property (@(posedge clk) disable iff (!rstN)
    modeWr |=> modeCur == $past(cfgModeBits));

  // R2: other loads leave the mode unchanged
  a_r2_mode_keep: assert property (@(posedge clk) disable iff (!rstN)
    !modeWr |=> $stable(modeCur));
endmodule

// File: rtl/slice_datapath.sv
module slice_datapath
  import lut_slice_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  sliceStrobe_t         strb,
  input  logic [LUT_BITS-1:0]  cfgData,
  output logic [N_TAB-1:0]     rd,
  output logic                 wide
);
  for (genvar g = 0; g < N_TAB; g++) begin : gTab
    lut_cell #(.IN_W(LUT_IN)) uCell (
      .clk      (clk),
      .rstN     (rstN),
      .load     (strb.load[g]),
      .loadData (cfgData),
      .write    (strb.write[g]),
      .wrAddr   (strb.wrAddr[g]),
      .wrBit    (strb.wrBit[g]),
      .shift    (strb.shift[g]),
      .shIn     (strb.shIn[g]),
      .rdAddr   (strb.rdAddr[g]),
      .rdOut    (rd[g])
    );
  end

  assign wide = strb.wideUseB ? rd[1] : rd[0];
endmodule

// File: rtl/lut_slice.sv
module lut_slice
  import lut_slice_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgLoad,
  input  logic [1:0]  cfgTarget,
  input  logic [15:0] cfgData,
  input  logic [3:0]  addrA,
  input  logic [3:0]  addrB,
  input  logic        addrHi,
  input  logic        wrEn,
  input  logic [1:0]  wrData,
  input  logic [1:0]  shiftIn,
  output logic        outA,
  output logic        outB,
  output logic        outWide
);
  sliceStrobe_t       strb;
  logic [MODE_W-1:0]  modeCur;
  logic [N_TAB-1:0]   rd;

  slice_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgLoad     (cfgLoad),
    .cfgTarget   (cfgTarget),
    .cfgModeBits (cfgData[MODE_W-1:0]),
    .addrA       (addrA),
    .addrB       (addrB),
    .addrHi      (addrHi),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .shiftIn     (shiftIn),
    .strb        (strb),
    .modeCur     (modeCur)
  );

  slice_datapath uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cfgData (cfgData),
    .rd      (rd),
    .wide    (outWide)
  );

  assign outA = rd[0];
  assign outB = rd[1];

  // R5: the wide memory reads back both bits written at addrA
  a_r5_pair_readback: assert property (@(posedge clk) disable iff (!rstN)
    (modeCur == MODE_RAM2W && wrEn && !cfgLoad) |=>
      ((addrA != $past(addrA)) || ({outB, outA} == $past(wrData))));

  // R7: the write port reads back its own write
  a_r7_port_readback: assert property (@(posedge clk) disable iff (!rstN)
    (modeCur == MODE_DUAL && wrEn && !cfgLoad) |=>
      ((addrA != $past(addrA)) || (outA == $past(wrData[0]))));

  // R10: unpaired modes route table A to the wide output
  a_r10_wide_default: assert property (@(posedge clk) disable iff (!rstN)
    (modeCur != MODE_RAM32 && modeCur != MODE_DUAL) |-> outWide == outA);
endmodule

// File: tb/sim_lut_slice.sv
`timescale 1ns/1ps
module sim_lut_slice;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [1:0]  cfgTarget = 2'd0;
  logic [15:0] cfgData = '0;
  logic [3:0]  addrA = '0;
  logic [3:0]  addrB = '0;
  logic        addrHi = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrData = '0;
  logic [1:0]  shiftIn = '0;
  logic        outA, outB, outWide;

  int nRun = 0;
  int nFail = 0;
  logic [15:0] refT [2];
  logic [2:0]  curMode = 3'd0;

  always #2.5 clk = ~clk;

  lut_slice u0 (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgTarget(cfgTarget),
    .cfgData(cfgData), .addrA(addrA), .addrB(addrB), .addrHi(addrHi),
    .wrEn(wrEn), .wrData(wrData), .shiftIn(shiftIn),
    .outA(outA), .outB(outB), .outWide(outWide)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic loadCfg(input logic [1:0] tgt, input logic [15:0] data);
    cfgLoad = 1'b1; cfgTarget = tgt; cfgData = data;
    tick();
    cfgLoad = 1'b0;
    if (tgt == 2'd2) curMode = data[2:0];
    else if (tgt != 2'd3) refT[tgt] = data;
  endtask

  // Sweep both tables through function mode, then restore the mode.
  task automatic dumpTables(input string req);
    logic [2:0] keep;
    keep = curMode;
    loadCfg(2'd2, 16'd0);
    for (int i = 0; i < 16; i++) begin
      addrA = 4'(i); addrB = 4'(i);
      #1;
      chk({req, " tabA"}, 16'(outA), 16'(refT[0][i]));
      chk({req, " tabB"}, 16'(outB), 16'(refT[1][i]));
    end
    loadCfg(2'd2, {13'd0, keep});
  endtask

  task automatic writeOp(input logic [3:0] a, input logic [3:0] b, input logic hi,
                         input logic [1:0] d, input logic [1:0] s);
    addrA = a; addrB = b; addrHi = hi; wrData = d; shiftIn = s; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic tReset();
    #1;
    chk("R1 outA", 16'(outA), 16'd0);
    chk("R1 outB", 16'(outB), 16'd0);
    chk("R1 outWide", 16'(outWide), 16'd0);
    refT[0] = '0; refT[1] = '0;
    dumpTables("R1");
  endtask

  task automatic tConfig();
    loadCfg(2'd0, 16'hA5C3);
    loadCfg(2'd1, 16'h0F96);
    dumpTables("R2 load");
    loadCfg(2'd3, 16'hFFFF);
    dumpTables("R2 target3");
    // load and write to the same table in one cycle: load wins
    loadCfg(2'd2, 16'd1);
    addrA = 4'd0; addrB = 4'd0; wrData = 2'b00; wrEn = 1'b1;
    cfgLoad = 1'b1; cfgTarget = 2'd0; cfgData = 16'h1234;
    tick();
    cfgLoad = 1'b0; wrEn = 1'b0;
    refT[0] = 16'h1234;
    refT[1][0] = 1'b0;
    dumpTables("R2 load beats write");
  endtask

  task automatic tFunc(input logic [2:0] m, input string req);
    loadCfg(2'd2, {13'd0, m});
    addrA = 4'd2; addrB = 4'd7;
    #1;
    chk({req, " read A"}, 16'(outA), 16'(refT[0][2]));
    chk({req, " read B"}, 16'(outB), 16'(refT[1][7]));
    chk("R10 wide func", 16'(outWide), 16'(outA));
    writeOp(4'd2, 4'd7, 1'b0, ~{refT[1][7], refT[0][2]}, 2'b11);
    dumpTables({req, " ignore write"});
  endtask

  task automatic tRam1();
    loadCfg(2'd2, 16'd1);
    writeOp(4'd3, 4'd9, 1'b0, {~refT[1][9], ~refT[0][3]}, 2'b00);
    refT[0][3] = ~refT[0][3]; refT[1][9] = ~refT[1][9];
    addrA = 4'd3; addrB = 4'd9;
    #1;
    chk("R4 read A", 16'(outA), 16'(refT[0][3]));
    chk("R4 read B", 16'(outB), 16'(refT[1][9]));
    chk("R10 wide ram1", 16'(outWide), 16'(outA));
    dumpTables("R4");
  endtask

  task automatic tRam2();
    loadCfg(2'd2, 16'd2);
    writeOp(4'd5, 4'd11, 1'b0, 2'b10, 2'b00);
    refT[0][5] = 1'b0; refT[1][5] = 1'b1;
    addrA = 4'd5; addrB = 4'd0;
    #1;
    chk("R5 bit0", 16'(outA), 16'd0);
    chk("R5 bit1", 16'(outB), 16'd1);
    writeOp(4'd5, 4'd11, 1'b0, 2'b01, 2'b00);
    refT[0][5] = 1'b1; refT[1][5] = 1'b0;
    dumpTables("R5");
  endtask

  task automatic tRam32();
    loadCfg(2'd2, 16'd3);
    writeOp(4'd7, 4'd0, 1'b1, {1'b0, ~refT[1][7]}, 2'b00);
    refT[1][7] = ~refT[1][7];
    writeOp(4'd7, 4'd0, 1'b0, {1'b0, ~refT[0][7]}, 2'b00);
    refT[0][7] = ~refT[0][7];
    addrA = 4'd7; addrHi = 1'b1;
    #1;
    chk("R6 upper", 16'(outWide), 16'(refT[1][7]));
    addrHi = 1'b0;
    #1;
    chk("R6 lower", 16'(outWide), 16'(refT[0][7]));
    dumpTables("R6");
  endtask

  task automatic tDual();
    loadCfg(2'd2, 16'd4);
    writeOp(4'd12, 4'd1, 1'b0, {1'b0, ~refT[0][12]}, 2'b00);
    refT[0][12] = ~refT[0][12];
    refT[1][12] = refT[0][12];
    addrA = 4'd12; addrB = 4'd1;
    #1;
    chk("R7 port A", 16'(outA), 16'(refT[0][12]));
    chk("R7 port B", 16'(outB), 16'(refT[1][1]));
    chk("R7 wide", 16'(outWide), 16'(refT[1][1]));
    addrB = 4'd12;
    #1;
    chk("R7 mirror", 16'(outB), 16'(refT[0][12]));
    dumpTables("R7");
  endtask

  task automatic tShift();
    logic [1:0] pat [4];
    pat[0] = 2'b01; pat[1] = 2'b10; pat[2] = 2'b11; pat[3] = 2'b00;
    loadCfg(2'd2, 16'd5);
    for (int k = 0; k < 4; k++) begin
      writeOp(4'd0, 4'd0, 1'b0, 2'b00, pat[k]);
      refT[0] = {refT[0][14:0], pat[k][0]};
      refT[1] = {refT[1][14:0], pat[k][1]};
    end
    addrA = 4'd3; addrB = 4'd2;
    #1;
    chk("R8 tap A", 16'(outA), 16'(refT[0][3]));
    chk("R8 tap B", 16'(outB), 16'(refT[1][2]));
    chk("R10 wide shift", 16'(outWide), 16'(outA));
    shiftIn = 2'b11; wrEn = 1'b0;
    tick();
    dumpTables("R8");
  endtask

  initial begin
    #(5.0 * 100000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tConfig();
    tFunc(3'd0, "R3");
    tFunc(3'd6, "R9 code6");
    tFunc(3'd7, "R9 code7");
    tRam1();
    tRam2();
    tRam32();
    tDual();
    tShift();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule